// File: doc/BRIEF.md
# Raster-Locked Interrupt Generator

This block produces a periodic, active-low processor interrupt request that stays in step with the video raster. A line counter advances once for each horizontal sync pulse. Each time the counter completes a period of 52 lines, it wraps to zero and sets an interrupt latch. The latch drives the interrupt output low and holds it there until the processor acknowledges the request or software clears it. The counter keeps running while a request waits.

Once per frame the block realigns to the vertical sync. Two lines after the vertical sync begins, it zeroes the counter and raises the first request of the frame, so the interrupts land at the same raster positions in every frame. A late acknowledge, arriving after the counter has entered its upper half, clears the counter's top bit. A software clear strobe does the same. Clearing that bit pushes the next request further out, so the interrupt handler is never crowded by a second interrupt.

Top module: `rirq_gen`

## Requirements
- R1: Each rising edge of `hsync_i` advances the 6-bit line counter by exactly one. A sync pulse held high for many clock cycles counts as one line.
- R2: When an advance would bring the counter to 52, the counter returns to 0 and `int_n_o` goes low. After reset, the first request comes on the 52nd line.
- R3: While a request is pending, lines keep being counted and `int_n_o` stays low until an acknowledge or a software clear.
- R4: An acknowledge is the onset of `m1_n_i` and `iorq_n_i` both being low. It releases `int_n_o` high.
- R5: An acknowledge of a pending request while counter bit 5 is set (count 32 or more) clears that bit. For example, an acknowledge at count 40 leaves 8, and the next request comes 44 lines later.
- R6: An acknowledge while no request is pending leaves the counter unchanged.
- R7: A one-cycle high on `sw_clr_i` releases `int_n_o` high and clears counter bit 5, whether or not that bit was set. For example, a clear at count 35 leaves 3.
- R8: After a rising edge of `vsync_i`, the second following line zeroes the counter and drives `int_n_o` low. With each request acknowledged at once, 312 lines counted from the vertical sync contain 6 requests.
- R9: If the line that completes a period and an acknowledge take effect in the same cycle, the request wins and `int_n_o` stays low.
- R10: Reset leaves `int_n_o` high, zeroes the counter and discards any vertical-sync delay in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high, asynchronous to clk |
| vsync_i | input | 1 | Vertical sync, active high, asynchronous to clk |
| m1_n_i | input | 1 | Processor opcode-fetch strobe, active low |
| iorq_n_i | input | 1 | Processor I/O request strobe, active low |
| sw_clr_i | input | 1 | Software clear strobe, synchronous to clk, active high |
| int_n_o | output | 1 | Interrupt request to the processor, active low |

## Verification
The counter cannot be seen at the ports, so every claim about it has to be read from the number of lines until the next request. The bench steers the counter to chosen values, such as 35, 40 and 51, by counting pulses. It then applies an acknowledge or a clear and measures the distance to the following request. The hardest case to reach is a line wrap that coincides with an acknowledge. The bench produces it by raising `hsync_i` and the acknowledge condition on the same clock edge, so both pass through synchronisers of equal depth and arrive together.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
   // number of asynchronous level inputs that are synchronised and edge detected
   localparam int unsigned RIRQ_NUM_IN = 3;

   // per-cycle single-shot events seen by the core
   typedef struct packed {
      logic ack;
      logic frame;
      logic line;
   } rirq_evt_t;
endpackage

// File: rtl/rirq_edge_sync.sv
module rirq_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_s;
   logic lvl_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign lvl_s = lvl_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= lvl_i;
               for (int i = 1; i < STAGES; i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign lvl_s = sh[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_s;
   end

   assign rise_o = lvl_s & ~lvl_q;
endmodule

// File: rtl/rirq_frame_align.sv
module rirq_frame_align #(
   parameter int unsigned LINES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_ev,
   input  logic line_ev,
   output logic fire_o
);
   localparam int unsigned W = $clog2(LINES + 1);

   logic [W-1:0] rem;
   logic         armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         armed <= 1'b0;
      end else if (frame_ev) begin
         armed <= 1'b1;
         rem   <= W'(LINES);
      end else if (line_ev && armed) begin
         if (rem == W'(1)) armed <= 1'b0;
         rem <= rem - 1'b1;
      end
   end

   assign fire_o = armed & line_ev & ~frame_ev & (rem == W'(1));
endmodule

// File: rtl/rirq_line_core.sv
module rirq_line_core #(
   parameter int unsigned CNT_W  = 6,
   parameter int unsigned PERIOD = 52
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_ev,
   input  logic             align_fire,
   input  logic             ack_ev,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             int_n_o
);
   localparam int unsigned TOP = CNT_W - 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt, cnt_nx;
   logic             pend, pend_nx;
   logic             wrap, set;

   always_comb begin
      wrap   = (cnt == LAST);
      set    = line_ev & (align_fire | wrap);
      cnt_nx = cnt;
      if (line_ev) cnt_nx = set ? '0 : cnt + 1'b1;
      if (clr_i || (ack_ev && pend && cnt[TOP])) cnt_nx[TOP] = 1'b0;
      if (set)                  pend_nx = 1'b1;
      else if (ack_ev || clr_i) pend_nx = 1'b0;
      else                      pend_nx = pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         cnt  <= cnt_nx;
         pend <= pend_nx;
      end
   end

   assign cnt_o   = cnt;
   assign int_n_o = ~pend;
endmodule

// File: rtl/rirq_gen.sv
module rirq_gen
   import rirq_pkg::*;
#(
   parameter int unsigned CNT_W       = 6,
   parameter int unsigned PERIOD      = 52,
   parameter int unsigned VS_LINES    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_i,
   input  logic vsync_i,
   input  logic m1_n_i,
   input  logic iorq_n_i,
   input  logic sw_clr_i,
   output logic int_n_o
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("rirq_gen: CNT_W must be at least 2");
      end
      if (PERIOD > (2 ** CNT_W) || PERIOD <= (2 ** (CNT_W - 1))) begin : g_bad_period
         $error("rirq_gen: PERIOD must lie in the upper half of the counter range");
      end
      if (VS_LINES < 1) begin : g_bad_delay
         $error("rirq_gen: VS_LINES must be at least 1");
      end
   endgenerate

   logic [RIRQ_NUM_IN-1:0] raw_lvl;
   logic [RIRQ_NUM_IN-1:0] rise;
   rirq_evt_t              evt;
   logic                   hs_ev, ack_ev, align_fire;
   logic [CNT_W-1:0]       cnt;

   assign raw_lvl = {~m1_n_i & ~iorq_n_i, vsync_i, hsync_i};

   generate
      for (genvar g = 0; g < RIRQ_NUM_IN; g++) begin : g_sync
         rirq_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (raw_lvl[g]),
            .rise_o (rise[g])
         );
      end
   endgenerate

   assign evt    = rirq_evt_t'(rise);
   assign hs_ev  = evt.line;
   assign ack_ev = evt.ack;

   rirq_frame_align #(.LINES(VS_LINES)) align_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_ev (evt.frame),
      .line_ev  (hs_ev),
      .fire_o   (align_fire)
   );

   rirq_line_core #(.CNT_W(CNT_W), .PERIOD(PERIOD)) core_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_ev    (hs_ev),
      .align_fire (align_fire),
      .ack_ev     (ack_ev),
      .clr_i      (sw_clr_i),
      .cnt_o      (cnt),
      .int_n_o    (int_n_o)
   );
endmodule

// File: rtl/rirq_gen_chk.sv
module rirq_gen_chk #(
   parameter int unsigned CNT_W  = 6,
   parameter int unsigned PERIOD = 52
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hs_ev,
   input logic             ack_ev,
   input logic             clr,
   input logic [CNT_W-1:0] cnt,
   input logic             int_n
);
   localparam int unsigned TOP = CNT_W - 1;

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(PERIOD));

   // R2
   int_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n) |-> $past(hs_ev));

   // R3
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_n && !ack_ev && !clr) |=> !int_n);

   // R4
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ev && !hs_ev) |=> int_n);

   // R5
   top_bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_n && ack_ev && cnt[TOP] && !hs_ev) |=> !cnt[TOP]);

   // R6
   idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_n && ack_ev && !hs_ev && !clr) |=> $stable(cnt));

   // R7
   sw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hs_ev) |=> (int_n && !cnt[TOP]));

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_ev && cnt == CNT_W'(PERIOD - 1)) |=> !int_n);
endmodule

bind rirq_gen rirq_gen_chk #(.CNT_W(CNT_W), .PERIOD(PERIOD)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .hs_ev  (hs_ev),
   .ack_ev (ack_ev),
   .clr    (sw_clr_i),
   .cnt    (cnt),
   .int_n  (int_n_o)
);

// File: tb/rirq_gen_tb_top.sv
module rirq_gen_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync = 1'b0, vsync = 1'b0, m1_n = 1'b1, iorq_n = 1'b1, sw_clr = 1'b0;
   logic int_n;

   int errs = 0;
   int checks = 0;

   always #5 clk = ~clk;

   rirq_gen dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .hsync_i  (hsync),
      .vsync_i  (vsync),
      .m1_n_i   (m1_n),
      .iorq_n_i (iorq_n),
      .sw_clr_i (sw_clr),
      .int_n_o  (int_n)
   );

   // op codes: 0 = lines, 1 = acknowledge, 2 = software clear
   // vector = {op[1:0], repeat[9:0], expected int_n}
   localparam int NV = 19;
   localparam logic [12:0] VEC [NV] = '{
      {2'd0, 10'd51, 1'b1},  // R2: no request before the 52nd line
      {2'd0, 10'd1,  1'b0},  // R2: 52nd line requests
      {2'd0, 10'd10, 1'b0},  // R3: pending, counter at 10
      {2'd1, 10'd1,  1'b1},  // R4: acknowledge releases
      {2'd0, 10'd41, 1'b1},  // R3: counting continued
      {2'd0, 10'd1,  1'b0},
      {2'd0, 10'd40, 1'b0},  // counter at 40, pending
      {2'd1, 10'd1,  1'b1},  // R5: late acknowledge, 40 -> 8
      {2'd0, 10'd43, 1'b1},  // R5: 44 lines to next request
      {2'd0, 10'd1,  1'b0},
      {2'd1, 10'd1,  1'b1},
      {2'd0, 10'd40, 1'b1},  // counter at 40, idle
      {2'd1, 10'd1,  1'b1},  // R6: idle acknowledge
      {2'd0, 10'd11, 1'b1},  // R6: counter kept 40
      {2'd0, 10'd1,  1'b0},
      {2'd0, 10'd35, 1'b0},  // counter at 35, pending
      {2'd2, 10'd1,  1'b1},  // R7: clear, 35 -> 3
      {2'd0, 10'd48, 1'b1},
      {2'd0, 10'd1,  1'b0}   // R7: 49 lines after clear
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input logic e);
      chk(int_n === e, req, int_n, e);
   endtask

   task automatic line(input int hi = 2);
      hsync = 1'b1;
      repeat (hi) @(negedge clk);
      hsync = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic ack();
      m1_n = 1'b0; iorq_n = 1'b0;
      repeat (2) @(negedge clk);
      m1_n = 1'b1; iorq_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic line_ack();
      hsync = 1'b1; m1_n = 1'b0; iorq_n = 1'b0;
      repeat (2) @(negedge clk);
      hsync = 1'b0; m1_n = 1'b1; iorq_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic soft_clr();
      sw_clr = 1'b1;
      @(negedge clk);
      sw_clr = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) line();
   endtask

   task automatic lines_to_int(output int n);
      n = 0;
      do begin
         line();
         n++;
      end while (int_n && n < 100);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int n;
      int seen;
      repeat (5) @(negedge clk);
      chk_int("R10 int_n in reset", 1'b1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_int("R10 int_n after reset", 1'b1);

      // table walk
      for (int v = 0; v < NV; v++) begin
         for (int r = 0; r < int'(VEC[v][10:1]); r++) begin
            case (VEC[v][12:11])
               2'd0: line();
               2'd1: ack();
               default: soft_clr();
            endcase
            chk_int($sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", v), VEC[v][0]);
         end
      end

      // R9: wrap and acknowledge together, counter at 51 with a request pending
      lines(51);
      chk_int("R9 pending before wrap", 1'b0);
      line_ack();
      chk_int("R9 request wins over acknowledge", 1'b0);
      ack();
      chk_int("R9 released", 1'b1);
      lines_to_int(n);
      chk(n == 52, "R9 counter wrapped to 0", n, 52);

      // R1: long sync pulse counts once
      ack();
      lines(50);
      line(20);
      chk_int("R1 long pulse counted once", 1'b1);
      line();
      chk_int("R1 request on 52nd line", 1'b0);

      // R8: frame alignment
      ack();
      lines(20);
      vsync = 1'b1;
      repeat (4) @(negedge clk);
      line();
      chk_int("R8 first line after vsync", 1'b1);
      line();
      chk_int("R8 second line after vsync", 1'b0);
      ack();
      lines_to_int(n);
      chk(n == 52, "R8 counter zeroed by alignment", n, 52);
      vsync = 1'b0;
      repeat (4) @(negedge clk);
      ack();
      lines(10);
      vsync = 1'b1;
      repeat (4) @(negedge clk);
      seen = 0;
      for (int i = 0; i < 312; i++) begin
         line();
         if (!int_n) begin
            seen++;
            ack();
         end
      end
      chk(seen == 6, "R8 requests per 312-line frame", seen, 6);
      vsync = 1'b0;
      repeat (4) @(negedge clk);

      // R10: reset during a vertical-sync delay
      vsync = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      vsync = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_int("R10 int_n high after mid-run reset", 1'b1);
      lines_to_int(n);
      chk(n == 52, "R10 delay and counter discarded", n, 52);

      summary();
   end
endmodule